// File: doc/BRIEF.md
# ADC Serial Command Front-End

This block is the digital command side of a successive-approximation converter. A host talks to it over three wires: a serial clock, a serial data line and an active-low select. Pulling select low does not start anything. The block waits for the first high data bit, takes it as the start of an 8-bit control byte, and shifts the rest of the byte in on rising serial-clock edges. It launches the requested operation on the serial-clock falling edge that follows the seventh bit, so the operation is already running while the last bit arrives.

All three serial inputs pass through a two-stage synchronizer into the system clock domain. A behavioural stub stands in for the converter core and the calibration engine. Counters model how long a conversion and a calibration take, and a fixed pattern stands in for the conversion result. A strobe output reports busy and idle, and its polarity follows the selected clock mode. A second select cycle followed by a new start bit abandons any operation still in flight.

Top module: `adc_cmd_frontend`

## Requirements
- R1: After reset, `strobe_o`=1, `unipolar_o`=0 (bipolar), `ext_clk_o`=0 (internal clock), `prog_o`=000, `done_o`=0 and `result_o`=0.
- R2: A falling select, and any number of low data bits, start nothing. While the block is idle with select low, the first high bit opens a control byte, including straight after a finished operation with no select pulse in between.
- R3: The control byte arrives MSB first as: bit 1 start, bit 2 polarity (1 = unipolar), bit 3 M1, bit 4 M0, bit 5 reserved, bit 6 P2, bit 7 P1, bit 8 P0. Polarity, clock mode, P2 and P1 take effect at launch. P0 takes effect on the eighth rising edge. `prog_o` = {P2,P1,P0}.
- R4: The operation launches on the serial-clock falling edge after bit 7. Busy becomes visible on the third system-clock edge after that falling edge reaches the input, not earlier.
- R5: A conversion keeps the block busy for CONV_CYCLES clock cycles. `done_o` is then high for exactly one cycle, the first idle cycle, and `result_o` shows RESULT_PATTERN in unipolar mode, or RESULT_PATTERN with its MSB inverted in bipolar mode.
- R6: M1=0, M0=1 requests a calibration. It stays busy for CAL_CYCLES cycles, then pulses `done_o`. It leaves `result_o` and the clock mode unchanged.
- R7: M1=1 selects external-clock mode and M1=0 with M0=0 selects internal-clock mode. In internal mode `strobe_o` is low while busy and high while idle. In external mode it is high while busy and low while idle.
- R8: While busy, high data bits with select held low since the start bit are ignored, and the operation runs to its full length.
- R9: If select is pulsed high then low during an operation, the next high bit aborts the operation (busy ends with no `done_o`) and opens a new control byte whose command then runs.
- R10: Select going high before bit 7 cancels the byte. Nothing launches and the configuration outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from host |
| sel_n_i | input | 1 | Active-low select from host |
| ser_dat_i | input | 1 | Serial command data |
| strobe_o | output | 1 | Busy/idle strobe, polarity set by clock mode |
| done_o | output | 1 | One-cycle pulse when an operation completes |
| result_o | output | RES_W | Stand-in conversion result |
| unipolar_o | output | 1 | 1 = unipolar, 0 = bipolar |
| ext_clk_o | output | 1 | 1 = external-clock mode |
| prog_o | output | 3 | Programmable bits {P2,P1,P0} |

## Verification
A serial-clock falling edge driven between clock edges reaches the launch logic after two synchronizer stages and is acted on at the third rising clock edge. The bench therefore expects no busy at the second sampling point after the launch edge and busy at the third. Busy then lasts exactly CONV_CYCLES or CAL_CYCLES sampling points, and `done_o` is due in the first idle sample. The monitor counts busy samples as `strobe_o == ext_clk_o` and checks each finished run against a queued expectation. An abort is queued as its own item, which demands a busy run that ends with no done pulse.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
  localparam int CTRL_LEN   = 8;
  localparam int LAUNCH_BIT = 7;
  localparam int CNT_BITS   = $clog2(CTRL_LEN + 1);
  localparam int SHIFT_LEN  = LAUNCH_BIT - 1;

  typedef struct packed {
    logic uni;
    logic m1;
    logic m0;
    logic p2;
    logic p1;
  } ctrl_t;
endpackage

// File: rtl/adc_cmd_sync.sv
module adc_cmd_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= RST_VAL;
        else if (s == 0) stg_q[s] <= d_i;
        else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else prev_q <= stg_q[STAGES-1];
  end

  assign q_o    = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/adc_cmd_deframer.sv
module adc_cmd_deframer
  import adc_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_rise,
  input  logic  sclk_fall,
  input  logic  sel_n,
  input  logic  dat,
  input  logic  busy,
  output logic  start_ok,
  output logic  launch,
  output ctrl_t cmd,
  output logic  p0_load,
  output logic  p0_bit
);
  logic                 cap_q, cap_d;
  logic                 rearm_q, rearm_d;
  logic [CNT_BITS-1:0]  cnt_q, cnt_d;
  logic [SHIFT_LEN-1:0] sh_q, sh_d;

  assign start_ok = !sel_n && sclk_rise && dat && !cap_q && (!busy || rearm_q);
  assign launch   = cap_q && !sel_n && sclk_fall && (cnt_q == CNT_BITS'(LAUNCH_BIT));
  assign p0_load  = cap_q && !sel_n && sclk_rise && (cnt_q == CNT_BITS'(LAUNCH_BIT));
  assign p0_bit   = dat;

  assign cmd.uni = sh_q[SHIFT_LEN-1];
  assign cmd.m1  = sh_q[SHIFT_LEN-2];
  assign cmd.m0  = sh_q[SHIFT_LEN-3];
  assign cmd.p2  = sh_q[1];
  assign cmd.p1  = sh_q[0];

  always_comb begin
    cap_d   = cap_q;
    rearm_d = rearm_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    if (sel_n) begin
      cap_d   = 1'b0;
      rearm_d = 1'b1;
    end else if (sclk_rise) begin
      if (cap_q) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q < CNT_BITS'(LAUNCH_BIT)) sh_d = {sh_q[SHIFT_LEN-2:0], dat};
        if (cnt_q == CNT_BITS'(CTRL_LEN - 1)) cap_d = 1'b0;
      end else if (start_ok) begin
        cap_d   = 1'b1;
        rearm_d = 1'b0;
        cnt_d   = CNT_BITS'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= 1'b0;
      rearm_q <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      cap_q   <= cap_d;
      rearm_q <= rearm_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
    end
  end
endmodule

// File: rtl/adc_cmd_engine.sv
module adc_cmd_engine #(
  parameter int               CONV_CYCLES    = 300,
  parameter int               CAL_CYCLES     = 80000,
  parameter int               RES_W          = 16,
  parameter logic [RES_W-1:0] RESULT_PATTERN = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             abort,
  input  logic             launch,
  input  logic             is_cal,
  input  logic             unipolar,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int MAXC  = (CAL_CYCLES > CONV_CYCLES) ? CAL_CYCLES : CONV_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [RES_W-1:0] BIP_RESULT =
    {~RESULT_PATTERN[RES_W-1], RESULT_PATTERN[RES_W-2:0]};

  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             cal_q, cal_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    cal_d  = cal_q;
    cnt_d  = cnt_q;
    res_d  = res_q;
    if (abort) begin
      busy_d = 1'b0;
    end else if (launch) begin
      busy_d = 1'b1;
      cal_d  = is_cal;
      cnt_d  = is_cal ? CNT_W'(CAL_CYCLES - 1) : CNT_W'(CONV_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        if (!cal_q) res_d = unipolar ? RESULT_PATTERN : BIP_RESULT;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cal_q  <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cal_q  <= cal_d;
      cnt_q  <= cnt_d;
      res_q  <= res_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/adc_cmd_frontend.sv
module adc_cmd_frontend
  import adc_cmd_pkg::*;
#(
  parameter int               CONV_CYCLES    = 300,
  parameter int               CAL_CYCLES     = 80000,
  parameter int               RES_W          = 16,
  parameter logic [RES_W-1:0] RESULT_PATTERN = 16'hA5C3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             sel_n_i,
  input  logic             ser_dat_i,
  output logic             strobe_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o,
  output logic             unipolar_o,
  output logic             ext_clk_o,
  output logic [2:0]       prog_o
);
  localparam logic [2:0] SYNC_RST = 3'b010;

  logic [2:0] s_lvl, s_rise, s_fall;
  logic       busy_w, launch_w, start_ok_w, p0_load_w, p0_bit_w, is_cal_w;
  ctrl_t      cmd_w;

  logic       uni_q, uni_d, ext_q, ext_d;
  logic [2:0] prog_q, prog_d;

  adc_cmd_sync #(.W(3), .STAGES(2), .RST_VAL(SYNC_RST)) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    ({ser_dat_i, sel_n_i, ser_clk_i}),
    .q_o    (s_lvl),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  adc_cmd_deframer i_deframer (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_rise (s_rise[0]),
    .sclk_fall (s_fall[0]),
    .sel_n     (s_lvl[1]),
    .dat       (s_lvl[2]),
    .busy      (busy_w),
    .start_ok  (start_ok_w),
    .launch    (launch_w),
    .cmd       (cmd_w),
    .p0_load   (p0_load_w),
    .p0_bit    (p0_bit_w)
  );

  assign is_cal_w = !cmd_w.m1 && cmd_w.m0;

  adc_cmd_engine #(
    .CONV_CYCLES    (CONV_CYCLES),
    .CAL_CYCLES     (CAL_CYCLES),
    .RES_W          (RES_W),
    .RESULT_PATTERN (RESULT_PATTERN)
  ) i_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (start_ok_w),
    .launch   (launch_w),
    .is_cal   (is_cal_w),
    .unipolar (uni_q),
    .busy     (busy_w),
    .done     (done_o),
    .result   (result_o)
  );

  always_comb begin
    uni_d  = uni_q;
    ext_d  = ext_q;
    prog_d = prog_q;
    if (launch_w) begin
      uni_d     = cmd_w.uni;
      ext_d     = is_cal_w ? ext_q : cmd_w.m1;
      prog_d[2] = cmd_w.p2;
      prog_d[1] = cmd_w.p1;
    end
    if (p0_load_w) prog_d[0] = p0_bit_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uni_q  <= 1'b0;
      ext_q  <= 1'b0;
      prog_q <= '0;
    end else begin
      uni_q  <= uni_d;
      ext_q  <= ext_d;
      prog_q <= prog_d;
    end
  end

  assign strobe_o   = ext_q ? busy_w : !busy_w;
  assign unipolar_o = uni_q;
  assign ext_clk_o  = ext_q;
  assign prog_o     = prog_q;
endmodule

// File: rtl/adc_cmd_frontend_chk.sv
module adc_cmd_frontend_chk (
  input logic clk,
  input logic rst_n,
  input logic strobe_o,
  input logic done_o,
  input logic unipolar_o,
  input logic ext_clk_o,
  input logic busy_w,
  input logic launch_w,
  input logic start_ok_w
);
  assert_cfg_at_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(unipolar_o) |-> $past(launch_w));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(busy_w) && !busy_w));

  assert_mode_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |=> $stable(ext_clk_o));

  assert_idle_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (strobe_o == !ext_clk_o));

  assert_abort_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_w) && !done_o) |-> $past(start_ok_w));
endmodule

bind adc_cmd_frontend adc_cmd_frontend_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strobe_o   (strobe_o),
  .done_o     (done_o),
  .unipolar_o (unipolar_o),
  .ext_clk_o  (ext_clk_o),
  .busy_w     (busy_w),
  .launch_w   (launch_w),
  .start_ok_w (start_ok_w)
);

// File: tb/test_adc_cmd_frontend.sv
module test_adc_cmd_frontend;
  localparam int          CLK_PERIOD = 10;
  localparam int          HALF       = 4;
  localparam int          CONV       = 60;
  localparam int          CAL        = 90;
  localparam logic [15:0] PAT        = 16'hA5C3;
  localparam logic [15:0] PAT_BIP    = 16'h25C3;

  typedef struct {
    bit          abort;
    int          dur;
    logic [15:0] res;
    string       tag;
  } exp_t;

  logic clk, rst_n, sclk, sel_n, dat;
  logic strobe, done, uni, ext;
  logic [15:0] result;
  logic [2:0]  prog;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  exp_t q[$];

  adc_cmd_frontend #(.CONV_CYCLES(CONV), .CAL_CYCLES(CAL), .RES_W(16),
                     .RESULT_PATTERN(PAT)) i_adc_cmd_frontend (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .sel_n_i(sel_n),
    .ser_dat_i(dat), .strobe_o(strobe), .done_o(done), .result_o(result),
    .unipolar_o(uni), .ext_clk_o(ext), .prog_o(prog));

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit busy_now();
    return strobe == ext;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input bit ab, input int dur, input logic [15:0] res, input string tag);
    exp_t e;
    e.abort = ab; e.dur = dur; e.res = res; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: scoreboard compare at end of each busy run
  int  run = 0;
  bit  was_busy = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy_now()) begin
        run++;
      end else if (was_busy) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected busy run of %0d cycles, expected none", run);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (e.abort) begin
            chk({e.tag, " abort no done"}, done, 0);
          end else begin
            chk({e.tag, " done pulse"}, done, 1);
            chk({e.tag, " busy length"}, run, e.dur);
            chk({e.tag, " result"}, result, e.res);
          end
        end
        run = 0;
      end
      was_busy = busy_now();
    end
  end

  task automatic send_bits(input int lead, input logic [7:0] b, input int n, input bit lat);
    for (int i = 0; i < lead + n; i++) begin
      @(negedge clk);
      dat = (i < lead) ? 1'b0 : b[7 - (i - lead)];
      repeat (HALF) @(negedge clk);
      sclk = 1;
      repeat (HALF) @(negedge clk);
      sclk = 0;
      if (lat && i == lead + 6) begin
        repeat (2) @(negedge clk);
        chk("R4 no busy before third edge", busy_now(), 0);
        @(negedge clk);
        chk("R4 busy at third edge", busy_now(), 1);
      end
    end
    @(negedge clk);
    dat = 0;
  endtask

  task automatic sel_pulse();
    @(negedge clk); sel_n = 1;
    repeat (6) @(negedge clk);
    sel_n = 0;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; sclk = 0; sel_n = 1; dat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 strobe", strobe, 1);
    chk("R1 unipolar", uni, 0);
    chk("R1 ext clock", ext, 0);
    chk("R1 prog", prog, 0);
    chk("R1 done", done, 0);
    chk("R1 result", result, 0);

    // R2: select falls, zeros only
    sel_n = 0;
    repeat (10) @(negedge clk);
    send_bits(10, 8'h00, 0, 0);
    repeat (10) @(negedge clk);
    chk("R2 no start on zeros", strobe, 1);
    chk("R2 prog untouched", prog, 0);

    // R3/R4/R5: unipolar internal conversion, leading zeros, prog 101
    push(0, CONV, PAT, "R5 unipolar conv");
    send_bits(3, 8'b1100_0101, 8, 1);
    wait_drain();
    chk("R3 unipolar set", uni, 1);
    chk("R3 internal mode", ext, 0);
    chk("R3 prog 101", prog, 3'b101);
    chk("R7 internal idle high", strobe, 1);

    // R7: external conversion, bipolar
    sel_pulse();
    push(0, CONV, PAT_BIP, "R5 bipolar conv");
    send_bits(0, 8'b1010_0011, 7, 1);
    chk("R7 external busy high", strobe, 1);
    send_bits(0, 8'b1000_0000, 1, 0);
    wait_drain();
    chk("R7 external mode", ext, 1);
    chk("R7 external idle low", strobe, 0);
    chk("R3 prog 011", prog, 3'b011);
    chk("R3 bipolar set", uni, 0);

    // R6: calibration keeps mode and result
    sel_pulse();
    push(0, CAL, PAT_BIP, "R6 calibration");
    send_bits(0, 8'b1101_0110, 8, 1);
    wait_drain();
    chk("R6 ext mode kept", ext, 1);
    chk("R6 result held", result, PAT_BIP);
    chk("R3 prog 110", prog, 3'b110);

    // R8: high bits during busy ignored; then idle start without select pulse
    sel_pulse();
    push(0, CONV, PAT_BIP, "R8 conv runs full");
    send_bits(0, 8'b1000_0000, 8, 1);
    send_bits(0, 8'hC0, 2, 0);
    wait_drain();
    chk("R8 internal mode", ext, 0);
    push(0, CONV, PAT, "R2 idle start no pulse");
    send_bits(0, 8'b1111_0000, 8, 1);
    wait_drain();
    chk("R2 ext from second byte", ext, 1);

    // R9: abort calibration via select pulse + new start bit
    sel_pulse();
    push(1, 0, 0, "R9 aborted cal");
    send_bits(0, 8'b1101_0000, 8, 1);
    repeat (20) @(negedge clk);
    sel_pulse();
    push(0, CONV, PAT_BIP, "R9 new conv");
    send_bits(0, 8'b1000_0111, 8, 1);
    wait_drain();
    chk("R9 prog 111", prog, 3'b111);
    chk("R9 internal mode", ext, 0);

    // R10: select high mid-byte cancels
    sel_pulse();
    send_bits(0, 8'b1110_0000, 4, 0);
    @(negedge clk); sel_n = 1;
    repeat (40) @(negedge clk);
    sel_n = 0;
    repeat (40) @(negedge clk);
    chk("R10 no launch", strobe, 1);
    chk("R10 prog kept", prog, 3'b111);
    chk("R10 unipolar kept", uni, 0);
    chk("R10 queue empty", q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule